// File: doc/BRIEF.md
# Banked Nibble Register File

This block is the working-register store of a 4-bit processor core. It keeps four banks of eight 4-bit registers. A two-bit bank number, loaded by a select-bank operation, decides which bank the register port addresses. Bank 0 is meant for the main program and banks 1 to 3 for interrupt handlers. A handler can therefore switch banks instead of saving registers. Inside a bank the registers are indexed A=0, E=1, L=2, H=3, X=4, W=5, Z=6, Y=7. They can be read and written one bit at a time, one nibble at a time, or as an 8-bit pair.

The same 32 nibbles also appear at the bottom of nibble-addressed data memory. A second port, the memory port, reaches every cell by flat address, whatever bank is selected. That port moves either one nibble or, at an even address, one byte made of two adjacent nibbles. Both ports read combinationally and write on the rising clock edge.

Top module: `nibble_bank_rf`

## Requirements
- R1: After reset the active bank is 0 and all 32 nibbles read as zero.
- R2: When `bank_sel_we` is high, `bank_sel_val` becomes the active bank at the next rising edge. A register access in that same cycle still uses the previous bank. Without `bank_sel_we` the bank holds its value.
- R3: Register index i of bank b occupies memory nibble address b*8+i, with indices A=0, E=1, L=2, H=3, X=4, W=5, Z=6, Y=7.
- R4: With `rp_size`=2 (pair), `rp_pair` selects the pair as follows: 0=EA, 1=HL, 2=WX, 3=YZ, 4=WL. The pair's data is {high register, low register}, in that order. EA has E high, HL has H high, WX has W high, YZ has Y high, and WL has W high with L low.
- R5: A pair code of 5 to 7 with `rp_size`=2, or `rp_size`=3, raises `rp_err`, reads 0 and writes nothing.
- R6: With `rp_size`=0 (bit), the read returns bit `rp_bitpos` of register `rp_idx` in `rp_rdata[0]`, with the other bits zero. A bit write copies `rp_wdata[0]` into that bit only, and the other three bits keep their values.
- R7: With `rp_size`=1 (nibble), the read returns the register in `rp_rdata[3:0]` and zero above it. A nibble write stores `rp_wdata[3:0]`.
- R8: With `mp_byte`=0 the memory port moves one nibble (data in bits 3:0). With `mp_byte`=1 and an even address, it moves a byte whose low half is the even nibble and whose high half is the next odd nibble.
- R9: With `mp_byte`=1 and an odd address, `mp_align_err` is high, the read returns 0 and a write changes no storage.
- R10: A write lands at the rising edge. A read in the same cycle, on either port, returns the old value; there is no bypass.
- R11: When both ports write the same nibble in one cycle, the register-port value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_sel_we | input | 1 | Load a new active bank |
| bank_sel_val | input | 2 | Bank number to load |
| active_bank | output | 2 | Currently selected bank |
| rp_we | input | 1 | Register-port write enable |
| rp_size | input | 2 | Access size: 0 bit, 1 nibble, 2 pair, 3 reserved |
| rp_idx | input | 3 | Register index for bit and nibble access |
| rp_pair | input | 3 | Pair code for pair access |
| rp_bitpos | input | 2 | Bit position for bit access |
| rp_wdata | input | 8 | Register-port write data |
| rp_rdata | output | 8 | Register-port read data, zero-extended |
| rp_err | output | 1 | Illegal size or pair code |
| mp_we | input | 1 | Memory-port write enable |
| mp_byte | input | 1 | 1 = byte access, 0 = nibble access |
| mp_addr | input | 5 | Flat nibble address |
| mp_wdata | input | 8 | Memory-port write data |
| mp_rdata | output | 8 | Memory-port read data, zero-extended |
| mp_align_err | output | 1 | Byte access at an odd address |

## Verification
The bench builds the block with its default parameters: four banks, eight registers per bank and 4-bit nibbles. With these values the memory port covers the whole 32-nibble space, so every register of every bank is checked against its flat address. The bank-0 to bank-3 switch and the cross-mapped WL pair in a non-zero bank are both reachable. The two widest cases are also covered: the top bank with the top register at address 1Fh, and a byte access at the last even address.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

  typedef enum logic [1:0] {
    SZ_BIT  = 2'd0,
    SZ_NIB  = 2'd1,
    SZ_PAIR = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    PR_EA = 3'd0,
    PR_HL = 3'd1,
    PR_WX = 3'd2,
    PR_YZ = 3'd3,
    PR_WL = 3'd4
  } pair_code_e;

  // register index within a bank (R3)
  localparam int unsigned IX_A = 0;
  localparam int unsigned IX_E = 1;
  localparam int unsigned IX_L = 2;
  localparam int unsigned IX_H = 3;
  localparam int unsigned IX_X = 4;
  localparam int unsigned IX_W = 5;
  localparam int unsigned IX_Z = 6;
  localparam int unsigned IX_Y = 7;

endpackage

// File: rtl/nrf_rst_sync.sv
module nrf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/nrf_bank_ctl.sv
module nrf_bank_ctl #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [BANK_W-1:0] sel_val,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = sel_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_q <= '0;
    else if (sel_we) bank_q <= bank_d;
  end

  assign bank = bank_q;

  // R2: load takes effect at the next edge
  a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> bank == $past(sel_val));

  // R2: bank persists without a select
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(bank));
endmodule

// File: rtl/nrf_pair_decode.sv
module nrf_pair_decode
  import nrf_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [2:0]       code,
  output logic [IDX_W-1:0] hi_idx,
  output logic [IDX_W-1:0] lo_idx,
  output logic             valid
);
  always_comb begin
    valid  = 1'b1;
    hi_idx = '0;
    lo_idx = '0;
    case (code)
      PR_EA: begin hi_idx = IDX_W'(IX_E); lo_idx = IDX_W'(IX_A); end
      PR_HL: begin hi_idx = IDX_W'(IX_H); lo_idx = IDX_W'(IX_L); end
      PR_WX: begin hi_idx = IDX_W'(IX_W); lo_idx = IDX_W'(IX_X); end
      PR_YZ: begin hi_idx = IDX_W'(IX_Y); lo_idx = IDX_W'(IX_Z); end
      PR_WL: begin hi_idx = IDX_W'(IX_W); lo_idx = IDX_W'(IX_L); end
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/nrf_cell_array.sv
module nrf_cell_array #(
  parameter int DEPTH = 32,
  parameter int NW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DEPTH-1:0]           we,
  input  logic [DEPTH-1:0][NW-1:0]   wd,
  output logic [DEPTH-1:0][NW-1:0]   q
);
  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    logic [NW-1:0] cell_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cell_q <= '0;
      else if (we[c]) cell_q <= wd[c];
    end

    assign q[c] = cell_q;
  end
endmodule

// File: rtl/nibble_bank_rf.sv
module nibble_bank_rf
  import nrf_pkg::*;
#(
  parameter  int NBANK  = 4,
  parameter  int NREG   = 8,
  parameter  int NW     = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(NREG),
  localparam int ADDR_W = BANK_W + IDX_W,
  localparam int DEPTH  = NBANK * NREG,
  localparam int BW     = 2 * NW,
  localparam int POS_W  = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel_we,
  input  logic [BANK_W-1:0] bank_sel_val,
  output logic [BANK_W-1:0] active_bank,
  input  logic              rp_we,
  input  logic [1:0]        rp_size,
  input  logic [IDX_W-1:0]  rp_idx,
  input  logic [2:0]        rp_pair,
  input  logic [POS_W-1:0]  rp_bitpos,
  input  logic [BW-1:0]     rp_wdata,
  output logic [BW-1:0]     rp_rdata,
  output logic              rp_err,
  input  logic              mp_we,
  input  logic              mp_byte,
  input  logic [ADDR_W-1:0] mp_addr,
  input  logic [BW-1:0]     mp_wdata,
  output logic [BW-1:0]     mp_rdata,
  output logic              mp_align_err
);
  logic                      rst_sync_n;
  acc_size_e                 sz;
  logic [IDX_W-1:0]          pd_hi;
  logic [IDX_W-1:0]          pd_lo;
  logic                      pd_valid;
  logic [ADDR_W-1:0]         rp_lo_addr;
  logic [ADDR_W-1:0]         rp_hi_addr;
  logic [ADDR_W-1:0]         mp_hi_addr;
  logic                      rp_ok;
  logic                      mp_odd;
  logic [NW-1:0]             bit_merged;
  logic [DEPTH-1:0]          cell_we;
  logic [DEPTH-1:0][NW-1:0]  cell_wd;
  logic [DEPTH-1:0][NW-1:0]  mem;

  nrf_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  nrf_bank_ctl #(.BANK_W(BANK_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel_we  (bank_sel_we),
    .sel_val (bank_sel_val),
    .bank    (active_bank)
  );

  nrf_pair_decode #(.IDX_W(IDX_W)) u_pair (
    .code   (rp_pair),
    .hi_idx (pd_hi),
    .lo_idx (pd_lo),
    .valid  (pd_valid)
  );

  nrf_cell_array #(.DEPTH(DEPTH), .NW(NW)) u_cells (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cell_we),
    .wd    (cell_wd),
    .q     (mem)
  );

  // address formation: flat address = {bank, index}
  always_comb begin
    sz         = acc_size_e'(rp_size);
    rp_lo_addr = {active_bank, (sz == SZ_PAIR) ? pd_lo : rp_idx};
    rp_hi_addr = {active_bank, pd_hi};
    rp_ok      = (sz != SZ_RSVD) && ((sz != SZ_PAIR) || pd_valid);
    mp_hi_addr = mp_addr | ADDR_W'(1);
    mp_odd     = mp_byte & mp_addr[0];
  end

  // register-port read
  always_comb begin
    rp_rdata = '0;
    case (sz)
      SZ_BIT:  rp_rdata[0]    = mem[rp_lo_addr][rp_bitpos];
      SZ_NIB:  rp_rdata[NW-1:0] = mem[rp_lo_addr];
      SZ_PAIR: if (pd_valid) rp_rdata = {mem[rp_hi_addr], mem[rp_lo_addr]};
      default: rp_rdata = '0;
    endcase
    rp_err = !rp_ok;
  end

  // memory-port read
  always_comb begin
    mp_rdata = '0;
    if (!mp_byte)    mp_rdata[NW-1:0] = mem[mp_addr];
    else if (!mp_odd) mp_rdata = {mem[mp_hi_addr], mem[mp_addr]};
    mp_align_err = mp_odd;
  end

  // write merge: memory port first, register port overrides
  always_comb begin
    bit_merged            = mem[rp_lo_addr];
    bit_merged[rp_bitpos] = rp_wdata[0];
    cell_we = '0;
    cell_wd = mem;
    if (mp_we) begin
      if (!mp_byte) begin
        cell_we[mp_addr] = 1'b1;
        cell_wd[mp_addr] = mp_wdata[NW-1:0];
      end else if (!mp_odd) begin
        cell_we[mp_addr]    = 1'b1;
        cell_wd[mp_addr]    = mp_wdata[NW-1:0];
        cell_we[mp_hi_addr] = 1'b1;
        cell_wd[mp_hi_addr] = mp_wdata[BW-1:NW];
      end
    end
    if (rp_we && rp_ok) begin
      cell_we[rp_lo_addr] = 1'b1;
      case (sz)
        SZ_BIT: cell_wd[rp_lo_addr] = bit_merged;
        SZ_NIB: cell_wd[rp_lo_addr] = rp_wdata[NW-1:0];
        default: begin
          cell_wd[rp_lo_addr] = rp_wdata[NW-1:0];
          cell_we[rp_hi_addr] = 1'b1;
          cell_wd[rp_hi_addr] = rp_wdata[BW-1:NW];
        end
      endcase
    end
  end

  // R9: misaligned byte write leaves storage untouched
  a_r9_odd_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mp_we && mp_byte && mp_addr[0] && !rp_we) |=> $stable(mem));

  // R5: illegal register access writes nothing
  a_r5_bad_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rp_we && rp_err && !mp_we) |=> $stable(mem));

  // R8: aligned byte write splits into low and high nibble
  a_r8_byte_split: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mp_we && mp_byte && !mp_addr[0] && !rp_we) |=>
      ({mem[$past(mp_addr) | ADDR_W'(1)], mem[$past(mp_addr)]} == $past(mp_wdata)));

  // R6: a bit write disturbs no other bit of the nibble
  a_r6_bit_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rp_we && sz == SZ_BIT && !mp_we) |=>
      (((mem[$past(rp_lo_addr)] ^ $past(mem[rp_lo_addr])) &
        ~(NW'(1) << $past(rp_bitpos))) == '0));

  // R11: register port wins a same-nibble collision
  a_r11_reg_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rp_we && sz == SZ_NIB && mp_we && !mp_byte && mp_addr == rp_lo_addr) |=>
      (mem[$past(rp_lo_addr)] == $past(rp_wdata[NW-1:0])));
endmodule

// File: tb/tb_nibble_bank_rf.sv
module tb_nibble_bank_rf;
  logic       clk;
  logic       rst_n;
  logic       bank_sel_we;
  logic [1:0] bank_sel_val;
  logic [1:0] active_bank;
  logic       rp_we;
  logic [1:0] rp_size;
  logic [2:0] rp_idx;
  logic [2:0] rp_pair;
  logic [1:0] rp_bitpos;
  logic [7:0] rp_wdata;
  logic [7:0] rp_rdata;
  logic       rp_err;
  logic       mp_we;
  logic       mp_byte;
  logic [4:0] mp_addr;
  logic [7:0] mp_wdata;
  logic [7:0] mp_rdata;
  logic       mp_align_err;

  nibble_bank_rf dut (
    .clk(clk), .rst_n(rst_n),
    .bank_sel_we(bank_sel_we), .bank_sel_val(bank_sel_val), .active_bank(active_bank),
    .rp_we(rp_we), .rp_size(rp_size), .rp_idx(rp_idx), .rp_pair(rp_pair),
    .rp_bitpos(rp_bitpos), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .rp_err(rp_err),
    .mp_we(mp_we), .mp_byte(mp_byte), .mp_addr(mp_addr), .mp_wdata(mp_wdata),
    .mp_rdata(mp_rdata), .mp_align_err(mp_align_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    string      req;
    logic [7:0] rp;
    logic       rperr;
    logic [7:0] mp;
    logic       merr;
    logic [1:0] bank;
  } item_t;

  item_t      sb_q[$];
  logic [3:0] mdl [32];
  logic [1:0] mbank;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 0;

  function automatic int pair_hi(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 3;
      3'd2: return 5;
      3'd3: return 7;
      3'd4: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int pair_lo(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expectation pushed to scoreboard
  task automatic step(input bit bsw, input logic [1:0] bsv,
                      input bit rwe, input logic [1:0] rsz, input logic [2:0] ridx,
                      input logic [2:0] rpr, input logic [1:0] rbit, input logic [7:0] rwd,
                      input bit mwe, input bit mby, input logic [4:0] mad, input logic [7:0] mwd,
                      input string req);
    item_t it;
    logic [3:0] pre [32];
    logic [3:0] nv;
    int lo, hi, ma;
    bit pv;
    @(negedge clk);
    #1;
    bank_sel_we = bsw; bank_sel_val = bsv;
    rp_we = rwe; rp_size = rsz; rp_idx = ridx; rp_pair = rpr; rp_bitpos = rbit; rp_wdata = rwd;
    mp_we = mwe; mp_byte = mby; mp_addr = mad; mp_wdata = mwd;
    ma = int'(mad);
    pv = (rpr <= 3'd4);
    lo = int'(mbank) * 8 + ((rsz == 2'd2) ? pair_lo(rpr) : int'(ridx));
    hi = int'(mbank) * 8 + pair_hi(rpr);
    it.req  = req;
    it.bank = mbank;
    case (rsz)
      2'd0: it.rp = {7'b0, mdl[lo][rbit]};
      2'd1: it.rp = {4'b0, mdl[lo]};
      2'd2: it.rp = pv ? {mdl[hi], mdl[lo]} : 8'h00;
      default: it.rp = 8'h00;
    endcase
    it.rperr = (rsz == 2'd3) || (rsz == 2'd2 && !pv);
    if (!mby)        it.mp = {4'b0, mdl[ma]};
    else if (mad[0]) it.mp = 8'h00;
    else             it.mp = {mdl[ma+1], mdl[ma]};
    it.merr = mby & mad[0];
    sb_q.push_back(it);
    pre = mdl;
    if (mwe) begin
      if (!mby) mdl[ma] = mwd[3:0];
      else if (!mad[0]) begin mdl[ma] = mwd[3:0]; mdl[ma+1] = mwd[7:4]; end
    end
    if (rwe && !it.rperr) begin
      case (rsz)
        2'd0: begin nv = pre[lo]; nv[rbit] = rwd[0]; mdl[lo] = nv; end
        2'd1: mdl[lo] = rwd[3:0];
        default: begin mdl[lo] = rwd[3:0]; mdl[hi] = rwd[7:4]; end
      endcase
    end
    if (bsw) mbank = bsv;
  endtask

  task automatic mrd(input bit by, input logic [4:0] a, input string req);
    step(0, 0, 0, 2'd1, 0, 0, 0, 0, 0, by, a, 0, req);
  endtask
  task automatic mwr(input bit by, input logic [4:0] a, input logic [7:0] d, input string req);
    step(0, 0, 0, 2'd1, 0, 0, 0, 0, 1, by, a, d, req);
  endtask
  task automatic rop(input bit we, input logic [1:0] sz, input logic [2:0] idx, input logic [2:0] pr,
                     input logic [1:0] bp, input logic [7:0] d, input string req);
    step(0, 0, we, sz, idx, pr, bp, d, 0, 0, 0, 0, req);
  endtask
  task automatic bsel(input logic [1:0] b, input string req);
    step(1, b, 0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  // monitor: pops expectations and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        cmp(it.req, "rp_rdata", rp_rdata, it.rp);
        cmp(it.req, "rp_err", {7'b0, rp_err}, {7'b0, it.rperr});
        cmp(it.req, "mp_rdata", mp_rdata, it.mp);
        cmp(it.req, "mp_align_err", {7'b0, mp_align_err}, {7'b0, it.merr});
        cmp(it.req, "active_bank", {6'b0, active_bank}, {6'b0, it.bank});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 4'h0;
    mbank = 2'd0;
    rst_n = 1'b0;
    bank_sel_we = 0; bank_sel_val = 0;
    rp_we = 0; rp_size = 2'd1; rp_idx = 0; rp_pair = 0; rp_bitpos = 0; rp_wdata = 0;
    mp_we = 0; mp_byte = 0; mp_addr = 0; mp_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state over the whole space
    for (int a = 0; a < 32; a++) mrd(0, 5'(a), "R1");

    // R2 / R3: fill every bank by name, check flat addresses
    for (int b = 0; b < 4; b++) begin
      bsel(2'(b), "R2");
      for (int i = 0; i < 8; i++) rop(1, 2'd1, 3'(i), 0, 0, {4'h0, 4'(b * 5 + i * 3 + 1)}, "R3");
    end
    for (int a = 0; a < 32; a++) mrd(0, 5'(a), "R3");
    for (int i = 0; i < 3; i++) rop(0, 2'd1, 3'd7, 0, 0, 0, "R2");
    // R2: same-cycle select still reads the old bank
    step(1, 2'd1, 0, 2'd1, 3'd0, 0, 0, 0, 0, 0, 0, 0, "R2");
    rop(0, 2'd1, 3'd0, 0, 0, 0, "R2");

    // R4: all pair codes in bank 2, plus WL and EA writes
    bsel(2'd2, "R2");
    for (int c = 0; c < 5; c++) rop(0, 2'd2, 0, 3'(c), 0, 0, "R4");
    rop(1, 2'd2, 0, 3'd4, 0, 8'hA5, "R4");
    mrd(0, 5'd21, "R4");
    mrd(0, 5'd18, "R4");
    rop(1, 2'd2, 0, 3'd0, 0, 8'h3C, "R4");
    mrd(1, 5'd16, "R4");

    // R5: illegal pair codes and reserved size
    for (int c = 5; c < 8; c++) rop(1, 2'd2, 0, 3'(c), 0, 8'hFF, "R5");
    rop(1, 2'd3, 3'd3, 0, 0, 8'hFF, "R5");
    for (int a = 16; a < 24; a += 2) mrd(1, 5'(a), "R5");

    // R6: bit writes and reads
    rop(1, 2'd0, 3'd3, 0, 2'd2, 8'h01, "R6");
    for (int p = 0; p < 4; p++) rop(0, 2'd0, 3'd3, 0, 2'(p), 0, "R6");
    rop(1, 2'd0, 3'd3, 0, 2'd0, 8'hFE, "R6");
    rop(1, 2'd0, 3'd3, 0, 2'd3, 8'h01, "R6");
    rop(0, 2'd1, 3'd3, 0, 0, 0, "R6");

    // R7: nibble reads in bank 2
    for (int i = 0; i < 8; i++) rop(0, 2'd1, 3'(i), 0, 0, 0, "R7");

    // R8: aligned byte write seen as the WX pair of bank 1
    bsel(2'd1, "R2");
    mwr(1, 5'h0C, 8'h96, "R8");
    rop(0, 2'd2, 0, 3'd2, 0, 0, "R8");
    mrd(1, 5'h0C, "R8");
    mwr(1, 5'h1E, 8'h7B, "R8");
    mrd(1, 5'h1E, "R8");
    mwr(0, 5'h0D, 8'hF4, "R8");
    mrd(1, 5'h0C, "R8");

    // R9: odd byte access
    mwr(1, 5'h07, 8'h5A, "R9");
    mrd(0, 5'h07, "R9");
    mrd(0, 5'h08, "R9");
    mrd(1, 5'h07, "R9");
    mwr(1, 5'h1F, 8'hCC, "R9");
    mrd(0, 5'h1F, "R9");

    // R10: same-cycle read returns the old value
    step(0, 0, 1, 2'd1, 3'd1, 0, 0, 8'h0E, 0, 0, 5'h09, 0, "R10");
    mrd(0, 5'h09, "R10");
    step(0, 0, 0, 2'd1, 3'd6, 0, 0, 0, 1, 0, 5'h0E, 8'h02, "R10");
    rop(0, 2'd1, 3'd6, 0, 0, 0, "R10");

    // R11: both ports write the same nibble
    step(0, 0, 1, 2'd1, 3'd2, 0, 0, 8'h03, 1, 0, 5'h0A, 8'h0C, "R11");
    mrd(0, 5'h0A, "R11");
    step(0, 0, 1, 2'd2, 0, 3'd1, 0, 8'h6D, 1, 1, 5'h0A, 8'h21, "R11");
    mrd(1, 5'h0A, "R11");

    rop(0, 2'd1, 0, 0, 0, 0, "R7");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule